// File: doc/BRIEF.md
# Dual-Port Memory with Per-Port Write Modes

A synchronous memory with two fully independent ports, A and B, on one common clock. Each port can read or write the shared storage array in any cycle. Each port has its own enable, write strobe, address, write data and registered read data. A read returns data on the clock edge after the address is presented.

What a port's read output shows during its own write cycle is set by a per-port parameter, which takes one of three values. In write-first mode it shows the data being written. In read-first mode it shows the contents the location held before the write. In no-change mode it keeps its previous value. A mode value outside the three legal codes stops elaboration.

When both ports use the same address in one cycle, a fixed rule applies. Port A wins a write-write collision. A port that reads a location the other port is writing sees the old contents.

Top module: `tdp_ram`

## Requirements
- R1: With enable high and write strobe low, the port's read output holds the array contents at the presented address from the next clock edge on. The output has one cycle of latency.
- R2: A port in write-first mode (parameter code 0) shows its own write data on its output after a write cycle. The data is also stored.
- R3: A port in read-first mode (parameter code 1) shows the contents the addressed location held before the write, after a write cycle. The new data is stored.
- R4: A port in no-change mode (parameter code 2) keeps its previous output value across a write cycle. The new data is stored.
- R5: While a port's enable is low, that port stores nothing and its output does not change, whatever its write strobe, address and data are.
- R6: The two ports' modes are independent. In one cycle, a write-first port A and a read-first port B each follow their own mode.
- R7: If both ports write the same address in one cycle, port A's data is stored. Each port's output still follows its own mode, using its own write data.
- R8: A port that reads an address being written by the other port in the same cycle returns the old contents. A later read returns the new data.
- R9: While rst_ni is low, both read outputs are zero. The array is not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Common clock |
| rst_ni | input | 1 | Active-low asynchronous reset for the output registers |
| a_en_i | input | 1 | Port A enable |
| a_we_i | input | 1 | Port A write strobe |
| a_addr_i | input | AW | Port A address |
| a_wdata_i | input | DW | Port A write data |
| a_rdata_o | output | DW | Port A registered read data |
| b_en_i | input | 1 | Port B enable |
| b_we_i | input | 1 | Port B write strobe |
| b_addr_i | input | AW | Port B address |
| b_wdata_i | input | DW | Port B write data |
| b_rdata_o | output | DW | Port B registered read data |

## Verification
Two functions can fall in the same cycle: a write through one port, and a read or write through the other port at the same address. The bench provokes this with two instances that share the same stimulus and use different mode pairings, so every mode meets a same-address collision. It judges the result from each port's output in the following cycle and from a later read-back of the contested location. The bench expects port A's data to be stored and the other port's read to return the old value.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;
  localparam int unsigned WM_WRITE_FIRST = 0;
  localparam int unsigned WM_READ_FIRST  = 1;
  localparam int unsigned WM_NO_CHANGE   = 2;
endpackage

// File: rtl/tdp_ram_array.sv
module tdp_ram_array #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_wr_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  input  logic          b_wr_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] a_old_o,
  output logic [DW-1:0] b_old_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // port A assigned last: wins a same-address write collision
  always_ff @(posedge clk_i) begin
    if (b_wr_i) mem_q[b_addr_i] <= b_wdata_i;
    if (a_wr_i) mem_q[a_addr_i] <= a_wdata_i;
  end

  // pre-edge contents; the other port's write lands after this edge
  assign a_old_o = mem_q[a_addr_i];
  assign b_old_o = mem_q[b_addr_i];

  a_r7_port_a_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_wr_i && b_wr_i && a_addr_i == b_addr_i)
    |=> mem_q[$past(a_addr_i)] == $past(a_wdata_i));

  a_r2_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_wr_i && !(b_wr_i && b_addr_i == a_addr_i))
    |=> mem_q[$past(a_addr_i)] == $past(a_wdata_i));
endmodule

// File: rtl/tdp_ram_port.sv
module tdp_ram_port
  import tdp_ram_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned MODE = WM_WRITE_FIRST
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] old_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] wr_view;

  generate
    if (MODE == WM_WRITE_FIRST) begin : g_wf
      assign wr_view = wdata_i;
      a_r2_write_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && we_i) |=> rdata_o == $past(wdata_i));
    end else if (MODE == WM_READ_FIRST) begin : g_rf
      assign wr_view = old_i;
      a_r3_read_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && we_i) |=> rdata_o == $past(old_i));
    end else if (MODE == WM_NO_CHANGE) begin : g_nc
      assign wr_view = rdata_q;
      a_r4_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && we_i) |=> $stable(rdata_o));
    end else begin : g_bad
      $error("tdp_ram_port: MODE must be 0, 1 or 2");
      assign wr_view = rdata_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (en_i) rdata_q <= we_i ? wr_view : old_i;
  end

  assign rdata_o = rdata_q;

  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(rdata_o));

  a_r1_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !we_i) |=> rdata_o == $past(old_i));
endmodule

// File: rtl/tdp_ram.sv
module tdp_ram
  import tdp_ram_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned MODE_A = WM_WRITE_FIRST,
  parameter int unsigned MODE_B = WM_READ_FIRST,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_en_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_en_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o
);
  logic          a_wr, b_wr;
  logic [DW-1:0] a_old, b_old;

  assign a_wr = a_en_i & a_we_i;
  assign b_wr = b_en_i & b_we_i;

  tdp_ram_array #(.DW(DW), .DEPTH(DEPTH)) u_array (
    .clk_i, .rst_ni,
    .a_wr_i(a_wr), .a_addr_i, .a_wdata_i,
    .b_wr_i(b_wr), .b_addr_i, .b_wdata_i,
    .a_old_o(a_old), .b_old_o(b_old)
  );

  tdp_ram_port #(.DW(DW), .MODE(MODE_A)) u_port_a (
    .clk_i, .rst_ni, .en_i(a_en_i), .we_i(a_we_i),
    .wdata_i(a_wdata_i), .old_i(a_old), .rdata_o(a_rdata_o)
  );

  tdp_ram_port #(.DW(DW), .MODE(MODE_B)) u_port_b (
    .clk_i, .rst_ni, .en_i(b_en_i), .we_i(b_we_i),
    .wdata_i(b_wdata_i), .old_i(b_old), .rdata_o(b_rdata_o)
  );

  a_r9_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (a_rdata_o == '0 && b_rdata_o == '0));
endmodule

// File: tb/tdp_ram_tb.sv
module tdp_ram_tb;
  localparam int DW = 16;
  localparam int AW = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic a_en, a_we, b_en, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wd, b_wd;
  logic [DW-1:0] a1, b1, a2, b2;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  // u_dut: A write-first, B read-first
  tdp_ram #(.DW(DW), .DEPTH(256), .MODE_A(0), .MODE_B(1)) u_dut (
    .clk_i, .rst_ni,
    .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wd), .a_rdata_o(a1),
    .b_en_i(b_en), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wd), .b_rdata_o(b1)
  );

  // u_dut2: A no-change, B write-first, same stimulus
  tdp_ram #(.DW(DW), .DEPTH(256), .MODE_A(2), .MODE_B(0)) u_dut2 (
    .clk_i, .rst_ni,
    .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wd), .a_rdata_o(a2),
    .b_en_i(b_en), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wd), .b_rdata_o(b2)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_a(input logic en, input logic we, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    a_en = en; a_we = we; a_addr = ad; a_wd = d;
  endtask

  task automatic set_b(input logic en, input logic we, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    b_en = en; b_we = we; b_addr = ad; b_wd = d;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R9 a1", a1, '0); chk("R9 b1", b1, '0);
    chk("R9 a2", a2, '0); chk("R9 b2", b2, '0);
  endtask

  task automatic t_preload();
    set_a(1, 1, 8'd3, 16'h3333);  set_b(1, 1, 8'd9, 16'h0909);  tick();
    set_a(1, 1, 8'd12, 16'h0C0C); set_b(1, 1, 8'd20, 16'h1414); tick();
    set_a(1, 1, 8'd7, 16'hAAAA);  set_b(0, 0, 8'd0, 16'h0);     tick();
    set_a(0, 0, 8'd0, 16'h0);     tick();
  endtask

  task automatic t_read();
    set_a(1, 0, 8'd3, 16'h0); set_b(1, 0, 8'd3, 16'h0);
    @(posedge clk_i); #1;
    set_a(0, 0, 8'd0, 16'h0); set_b(0, 0, 8'd0, 16'h0);
    @(negedge clk_i);
    chk("R1 a1", a1, 16'h3333); chk("R1 b1", b1, 16'h3333);
    chk("R1 a2", a2, 16'h3333); chk("R1 b2", b2, 16'h3333);
  endtask

  task automatic t_modes();
    set_a(1, 1, 8'd7, 16'hBBBB); set_b(1, 1, 8'd9, 16'h9999); tick();
    chk("R2 R6 a1 write-first", a1, 16'hBBBB);
    chk("R3 R6 b1 read-first", b1, 16'h0909);
    chk("R4 a2 no-change", a2, 16'h3333);
    chk("R2 b2 write-first", b2, 16'h9999);
    set_a(1, 0, 8'd7, 16'h0); set_b(1, 0, 8'd9, 16'h0); tick();
    chk("R3 R4 stored A", a2, 16'hBBBB);
    chk("R2 R3 stored B", b1, 16'h9999);
  endtask

  task automatic t_disabled();
    set_a(0, 1, 8'd9, 16'hDEAD); set_b(0, 1, 8'd7, 16'hBEEF); tick();
    chk("R5 a1 hold", a1, 16'hBBBB); chk("R5 b1 hold", b1, 16'h9999);
    chk("R5 a2 hold", a2, 16'hBBBB); chk("R5 b2 hold", b2, 16'h9999);
    set_a(1, 0, 8'd9, 16'h0); set_b(1, 0, 8'd7, 16'h0); tick();
    chk("R5 no write A", a1, 16'h9999); chk("R5 no write B", b1, 16'hBBBB);
  endtask

  task automatic t_collision();
    set_a(1, 1, 8'd12, 16'hA12A); set_b(1, 1, 8'd12, 16'hB12B); tick();
    chk("R7 a1 own data", a1, 16'hA12A);
    chk("R7 b1 old", b1, 16'h0C0C);
    chk("R7 a2 hold", a2, 16'h9999);
    chk("R7 b2 own data", b2, 16'hB12B);
    set_a(0, 0, 8'd0, 16'h0); set_b(1, 0, 8'd12, 16'h0); tick();
    chk("R7 A wins", b1, 16'hA12A); chk("R7 A wins dut2", b2, 16'hA12A);
  endtask

  task automatic t_cross();
    set_a(1, 1, 8'd20, 16'h2222); set_b(1, 0, 8'd20, 16'h0); tick();
    chk("R8 b1 old", b1, 16'h1414); chk("R8 b2 old", b2, 16'h1414);
    set_a(0, 0, 8'd0, 16'h0); tick();
    chk("R8 b1 new", b1, 16'h2222); chk("R8 b2 new", b2, 16'h2222);
  endtask

  initial begin
    set_a(0, 0, 8'd0, 16'h0); set_b(0, 0, 8'd0, 16'h0);
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_preload();
    t_read();
    t_modes();
    t_disabled();
    t_collision();
    t_cross();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog R1: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule